// File: doc/BRIEF.md
# DMA Acknowledge Strobe Generator

This block drives the acknowledge strobes of a four-channel DMA controller that moves data in dual-address mode, where every transfer is a read bus cycle followed by a write bus cycle. The bus sequencer supplies the number of the channel currently transferring, a flag that is high when that channel runs in dual-address mode, and one strobe for each of the two bus phases. For each channel that has an acknowledge pin, the block asserts that pin during the phase the channel is configured for. It drives the pin at the polarity the channel is configured for.

Each channel has a control register that software reaches through a simple write and read port. Two bits of this register set the acknowledge behaviour. The phase-select bit at position 17 picks the write phase when it is 1 and the read phase when it is 0. The polarity bit at position 16 makes the strobe active-high when it is 1 and active-low when it is 0. Only channels 0 and 1 hold these bits. On channels 2 and 3 the bits are fixed at zero. Every other bit of every control register reads as zero.

Top module: `dack_gen`

## Requirements
- R1: After reset, the phase-select bit and the polarity bit of every channel are 0, every register reads 0, and every acknowledge pin sits high (inactive, because active-low).
- R2: A write to channel 0 or channel 1 stores wdata bit 17 as that channel's phase-select bit and wdata bit 16 as its polarity bit. A read of that channel returns the two bits at positions 17 and 16.
- R3: Writes to channels 2 and 3 are discarded. Reads of channels 2 and 3 always return 0.
- R4: Read data is 0 in every bit position other than 17 and 16, whatever value was written.
- R5: With phase-select at 0, a channel's pin is asserted while all three of these hold: that channel is the active channel, the dual-address flag is high, and the read-phase strobe is high.
- R6: With phase-select at 1, a channel's pin is asserted while all three of these hold: that channel is the active channel, the dual-address flag is high, and the write-phase strobe is high.
- R7: With polarity at 0, an asserted pin drives 0. With polarity at 1, an asserted pin drives 1.
- R8: A pin that is not asserted sits at its inactive level, which is the inverse of its polarity bit. This covers the cases where another channel is active, where the dual-address flag is low, and where the selected strobe is low.
- R9: A polarity change written to a channel shows on its pin in the clock cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Channel whose control register is written or read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Control register of the selected channel (combinational) |
| act_ch_i | input | 2 | Channel currently transferring |
| dual_mode_i | input | 1 | High when the active transfer runs in dual-address mode |
| rd_phase_i | input | 1 | Read bus phase strobe |
| wr_phase_i | input | 1 | Write bus phase strobe |
| dack_o | output | 2 | Acknowledge pins of channels 0 and 1 |

## Verification
A corrupted polarity bit shows at once as a wrong idle level on the pin. It is also visible on readback in the same cycle, when the register select points at that channel. A corrupted phase-select bit stays hidden on the pin until that channel is active and one of the phase strobes is high. At that point the pin moves in the wrong phase, or the readback shows the bad bit. The bench therefore sweeps every configuration of both channels against every combination of active channel, dual-address flag and strobe. It compares the pins and the read data with its model on every clock. A stuck or leaking bit on channels 2 and 3 is caught by readback right after the write.

// File: rtl/dack_pkg.sv
package dack_pkg;
  localparam int unsigned MODE_BIT  = 17;
  localparam int unsigned LEVEL_BIT = 16;

  typedef struct packed {
    logic ack_wr;  // 1: acknowledge in write phase
    logic ack_hi;  // 1: active-high strobe
  } ack_cfg_t;
endpackage

// File: rtl/dack_cfg_regs.sv
module dack_cfg_regs
  import dack_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_ACK_CH = 2,
  localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CH_W-1:0] sel_i,
  input  ack_cfg_t        wcfg_i,
  output ack_cfg_t        cfg_o [NUM_CH]
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch < NUM_ACK_CH) begin : g_store
      localparam logic [CH_W-1:0] ID = CH_W'(ch);
      ack_cfg_t cfg_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cfg_q <= '0;
        else if (we_i && (sel_i == ID))  cfg_q <= wcfg_i;
      end

      assign cfg_o[ch] = cfg_q;

      p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == ID) |=> (cfg_o[ch] == $past(wcfg_i)));

      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && sel_i == ID) |=> $stable(cfg_o[ch]));
    end else begin : g_fixed
      assign cfg_o[ch] = '0;
    end
  end

endmodule

// File: rtl/dack_phase_sel.sv
module dack_phase_sel
  import dack_pkg::*;
#(
  parameter int unsigned CH_W  = 2,
  parameter int unsigned CH_ID = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] act_ch_i,
  input  logic            dual_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  ack_cfg_t        cfg_i,
  output logic            dack_o
);

  localparam logic [CH_W-1:0] ID = CH_W'(CH_ID);

  logic mine;
  logic phase_hit;
  logic active;

  assign mine      = dual_i && (act_ch_i == ID);
  assign phase_hit = cfg_i.ack_wr ? wr_i : rd_i;
  assign active    = mine && phase_hit;
  assign dack_o    = cfg_i.ack_hi ? active : ~active;

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i || act_ch_i != ID) |-> (dack_o == ~cfg_i.ack_hi));

  p_rd_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && act_ch_i == ID && !cfg_i.ack_wr && rd_i) |-> (dack_o == cfg_i.ack_hi));

  p_wr_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_i && act_ch_i == ID && cfg_i.ack_wr && wr_i) |-> (dack_o == cfg_i.ack_hi));

  p_wrong_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.ack_wr ? !wr_i : !rd_i) |-> (dack_o == ~cfg_i.ack_hi));

endmodule

// File: rtl/dack_gen.sv
module dack_gen
  import dack_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_ACK_CH = 2,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CH_W-1:0]   reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CH_W-1:0]   act_ch_i,
  input  logic              dual_mode_i,
  input  logic              rd_phase_i,
  input  logic              wr_phase_i,
  output logic [NUM_ACK_CH-1:0] dack_o
);

  ack_cfg_t wcfg;
  ack_cfg_t cfg [NUM_CH];
  ack_cfg_t rcfg;
  logic     unused_wdata;

  assign wcfg.ack_wr  = reg_wdata_i[MODE_BIT];
  assign wcfg.ack_hi  = reg_wdata_i[LEVEL_BIT];
  assign unused_wdata = ^reg_wdata_i;

  dack_cfg_regs #(
    .NUM_CH     (NUM_CH),
    .NUM_ACK_CH (NUM_ACK_CH)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .sel_i  (reg_sel_i),
    .wcfg_i (wcfg),
    .cfg_o  (cfg)
  );

  assign rcfg = cfg[reg_sel_i];

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[MODE_BIT]  = rcfg.ack_wr;
    reg_rdata_o[LEVEL_BIT] = rcfg.ack_hi;
  end

  for (genvar ch = 0; ch < NUM_ACK_CH; ch++) begin : g_ack
    dack_phase_sel #(
      .CH_W  (CH_W),
      .CH_ID (ch)
    ) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_ch_i (act_ch_i),
      .dual_i   (dual_mode_i),
      .rd_i     (rd_phase_i),
      .wr_i     (wr_phase_i),
      .cfg_i    (cfg[ch]),
      .dack_o   (dack_o[ch])
    );
  end

  p_fixed_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_sel_i) >= NUM_ACK_CH) |-> (reg_rdata_o == '0));

  p_other_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_rdata_o & ~((DATA_W'(1) << MODE_BIT) | (DATA_W'(1) << LEVEL_BIT))) == '0));

  p_level_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && int'(reg_sel_i) < NUM_ACK_CH && !dual_mode_i)
      |=> (dack_o[$past(reg_sel_i)] == ~$past(reg_wdata_i[LEVEL_BIT])));

endmodule

// File: tb/dack_gen_test.sv
`timescale 1ns/1ps
module dack_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [1:0]  sel = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  act = 0;
  logic        dual = 0;
  logic        rd = 0;
  logic        wr = 0;
  logic [1:0]  dack;

  int tests = 0;
  int fails = 0;
  bit running = 0;
  string cur_req = "R1";

  bit m_mode [4];
  bit m_level[4];

  always #4 clk = ~clk;

  dack_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .act_ch_i(act),
    .dual_mode_i(dual), .rd_phase_i(rd), .wr_phase_i(wr), .dack_o(dack)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_mode[i] <= 0; m_level[i] <= 0; end
    end else if (we && sel < 2) begin
      m_mode[sel]  <= wdata[17];
      m_level[sel] <= wdata[16];
    end
  end

  function automatic logic [1:0] exp_dack();
    logic [1:0] r;
    for (int i = 0; i < 2; i++) begin
      bit hit;
      hit  = (act == i) && dual && (m_mode[i] ? wr : rd);
      r[i] = m_level[i] ? hit : !hit;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = 0;
    if (sel < 2) begin r[17] = m_mode[sel]; r[16] = m_level[sel]; end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk(cur_req, {30'd0, dack}, {30'd0, exp_dack()});
    chk(cur_req, rdata, exp_rdata());
  end

  task automatic reg_write(logic [1:0] ch, logic [31:0] d);
    @(posedge clk); #1 we = 1; sel = ch; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic read_chk(string tag, logic [1:0] ch, logic [31:0] e);
    @(posedge clk); #1 sel = ch;
    @(negedge clk); chk(tag, rdata, e);
  endtask

  task automatic drive(logic [1:0] a, bit d, bit r, bit w);
    @(posedge clk); #1 act = a; dual = d; rd = r; wr = w;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", {30'd0, dack}, 32'h3);
    for (int c = 0; c < 4; c++) read_chk("R1", c[1:0], 32'h0);
    running = 1;

    cur_req = "R2";
    reg_write(0, 32'hFFFF_FFFF);
    read_chk("R4", 0, 32'h0003_0000);
    reg_write(0, 32'h0002_0000);
    read_chk("R2", 0, 32'h0002_0000);

    cur_req = "R9";
    @(posedge clk); #1 sel = 1;
    reg_write(1, 32'h0001_0000);
    @(negedge clk); chk("R9", {31'd0, dack[1]}, 32'h0);
    reg_write(1, 32'h0000_0000);
    @(negedge clk); chk("R9", {31'd0, dack[1]}, 32'h1);

    cur_req = "R3";
    reg_write(2, 32'hFFFF_FFFF);
    read_chk("R3", 2, 32'h0);
    reg_write(3, 32'h0003_0000);
    read_chk("R3", 3, 32'h0);
    read_chk("R3", 1, 32'h0);

    // ch0: write phase, active-low; ch1: read phase, active-low
    cur_req = "R6";
    drive(0, 1, 1, 0);
    @(negedge clk); chk("R6", {31'd0, dack[0]}, 32'h1);
    drive(0, 1, 0, 1);
    @(negedge clk); chk("R6", {31'd0, dack[0]}, 32'h0);
    cur_req = "R5";
    drive(1, 1, 1, 0);
    @(negedge clk); chk("R5", {30'd0, dack}, 32'h1);
    cur_req = "R8";
    drive(1, 0, 1, 1);
    @(negedge clk); chk("R8", {30'd0, dack}, 32'h3);
    drive(2, 1, 1, 1);
    @(negedge clk); chk("R8", {30'd0, dack}, 32'h3);

    cur_req = "R7";
    reg_write(1, 32'h0001_0000);
    drive(1, 1, 1, 0);
    @(negedge clk); chk("R7", {31'd0, dack[1]}, 32'h1);
    drive(1, 1, 0, 1);
    @(negedge clk); chk("R7", {31'd0, dack[1]}, 32'h0);

    cur_req = "R5 R6 R7 R8";
    for (int cfgv = 0; cfgv < 16; cfgv++) begin
      drive(0, 0, 0, 0);
      reg_write(0, {14'd0, cfgv[1], cfgv[0], 16'd0});
      reg_write(1, {14'd0, cfgv[3], cfgv[2], 16'd0});
      for (int a = 0; a < 4; a++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 4; p++) begin
            drive(a[1:0], d[0], p[0], p[1]);
            @(posedge clk); #1 sel = a[1:0];
          end
    end

    drive(0, 0, 0, 0);
    @(negedge clk);
    running = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule